// File: doc/BRIEF.md
# Prioritized Pad Function Multiplexer

This block assigns each pad of a bank of bidirectional pads to one of up to five function slots. Slot 0 is the default function of a pad and has no enable. Slots 1 to 4 each name one bit of a combined enable vector. That vector is formed from two control registers held inside the block. Among the slots whose enable bit is high, the highest-numbered one owns the pad. When none is high, slot 0 owns it.

The owning slot's output value is driven onto the pad. The pad output enable follows the slot's fixed direction: an input-only slot never drives, an output-only slot always drives, and a bidirectional slot passes the peripheral's own output enable. The pad input is returned only to the owning slot's input port. Every other input port sees a constant idle level taken from the pad map.

The pad map is a parameter. It gives the direction, idle level and enable-bit index of every slot of every pad. The same enable bit may appear in several slots, so one control bit can move a whole group of pads together.

Top module: `pfm_top`

## Requirements
- R1: A synchronous active-high reset clears both enable registers, so both read back zero and every pad is owned by slot 0.
- R2: When no present slot 1 to 4 of a pad has its enable bit high, slot 0 owns the pad.
- R3: When several slots of a pad have their enable bits high, the highest-numbered slot owns it (4 over 3 over 2 over 1).
- R4: The enable vector places the control register (address 0) at indices 0 to 23 and the shared-channel register (address 1) at indices 24 to 45, so shared bit k is index 24+k. One enable index may be used by several slots and pads, and all of them react together.
- R5: pad_do carries fn_do of the owning slot. pad_oe is 0 for an input-only slot (direction code 1), 1 for an output-only slot (code 2), and the slot's fn_oe for a bidirectional slot (code 3).
- R6: The owning slot's fn_di receives pad_di when that slot is input-only or bidirectional. Every other fn_di bit of the pad holds that slot's configured idle level.
- R7: A slot marked absent (direction code 0) ignores its enable bit. If the owning slot is absent, the pad drives 0 with pad_oe low.
- R8: When cfg_we is high at a rising clock edge, cfg_wdata is stored into the register chosen by cfg_addr. The control register keeps only bits 0 to 13 and 16 to 23, and the shared register keeps bits 0 to 21. Bits that are not kept read back as zero on cfg_rdata, which shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the enable registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the control register, 1 selects the shared-channel register |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Contents of the addressed register |
| fn_do | input | NUM_PADS x 5 | Output value from each function slot of each pad |
| fn_oe | input | NUM_PADS x 5 | Output enable from each function slot (used by bidirectional slots) |
| fn_di | output | NUM_PADS x 5 | Input value delivered to each function slot of each pad |
| pad_di | input | NUM_PADS | Value received from each pad |
| pad_do | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Output enable to each pad driver |

## Verification
The bench builds the block with NUM_PADS set to 4 and its own pad map. The register widths and keep-mask stay at their defaults. In that map, one control bit feeds slots 1 and 2 of a pad and is shared across two pads, and one slot is absent although its enable bit is in use. Slot 0 of one pad is input-only, and another pad has only slot 0. All directions and both idle levels occur, and the top shared bit (index 45) is used. So every priority, direction and idle case is reachable, both by directed writes and by random register and pad values.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    localparam int NUM_SLOTS  = 5;
    localparam int SEL_W      = 3;
    localparam int IDX_W      = 6;
    localparam int SHARE_BASE = 24;
    localparam int DEF_PADS   = 9;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_IN   = 2'd1,
        DIR_OUT  = 2'd2,
        DIR_BI   = 2'd3
    } dir_e;

    typedef struct packed {
        dir_e             dir;
        logic             idle;
        logic [IDX_W-1:0] en_idx;
    } slot_cfg_t;

    typedef slot_cfg_t [NUM_SLOTS-1:0] pad_cfg_t;
    typedef pad_cfg_t [DEF_PADS-1:0]   def_map_t;

    function automatic slot_cfg_t mk_slot(dir_e d, logic idle, int idx);
        slot_cfg_t c;
        c.dir    = d;
        c.idle   = idle;
        c.en_idx = IDX_W'(idx);
        return c;
    endfunction

    // Default bank: general pads, quad-SPI, two SPI masters, SPI slave,
    // debug port, RF interface and shared channels.
    function automatic def_map_t default_map();
        def_map_t m;
        m = '0;
        m[0][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[0][1] = mk_slot(DIR_OUT, 1'b0, 0);
        m[1][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[1][1] = mk_slot(DIR_BI,  1'b0, 1);
        m[2][0] = mk_slot(DIR_IN,  1'b0, 0);
        m[2][1] = mk_slot(DIR_BI,  1'b0, 9);
        m[3][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[3][1] = mk_slot(DIR_OUT, 1'b0, 5);
        m[3][3] = mk_slot(DIR_BI,  1'b0, SHARE_BASE + 0);
        m[4][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[4][1] = mk_slot(DIR_OUT, 1'b0, 4);
        m[4][2] = mk_slot(DIR_IN,  1'b1, 8);
        m[4][3] = mk_slot(DIR_BI,  1'b0, SHARE_BASE + 1);
        m[5][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[5][1] = mk_slot(DIR_IN,  1'b0, 4);
        m[5][2] = mk_slot(DIR_OUT, 1'b0, 8);
        m[5][3] = mk_slot(DIR_BI,  1'b0, SHARE_BASE + 2);
        m[6][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[6][1] = mk_slot(DIR_OUT, 1'b0, 6);
        m[6][2] = mk_slot(DIR_OUT, 1'b0, 16);
        m[6][3] = mk_slot(DIR_BI,  1'b0, SHARE_BASE + 3);
        m[6][4] = mk_slot(DIR_IN,  1'b0, 13);
        m[7][0] = mk_slot(DIR_IN,  1'b1, 0);
        m[7][1] = mk_slot(DIR_BI,  1'b0, 12);
        m[7][2] = mk_slot(DIR_OUT, 1'b0, 17);
        m[7][3] = mk_slot(DIR_BI,  1'b0, SHARE_BASE + 4);
        m[7][4] = mk_slot(DIR_IN,  1'b0, 13);
        m[8][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[8][2] = mk_slot(DIR_OUT, 1'b0, 23);
        m[8][3] = mk_slot(DIR_BI,  1'b0, SHARE_BASE + 21);
        m[8][4] = mk_slot(DIR_OUT, 1'b0, 13);
        return m;
    endfunction

endpackage

// File: rtl/pfm_regs.sv
module pfm_regs #(
    parameter int                DATA_W    = 32,
    parameter int                CTRL_W    = 24,
    parameter int                SHARE_W   = 22,
    parameter logic [CTRL_W-1:0] CTRL_MASK = 24'hFF3FFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic               addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [CTRL_W-1:0]  ctrl_q,
    output logic [SHARE_W-1:0] share_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            share_q <= '0;
        end else if (we) begin
            if (addr) share_q <= wdata[SHARE_W-1:0];
            else      ctrl_q  <= wdata[CTRL_W-1:0] & CTRL_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) rdata[SHARE_W-1:0] = share_q;
        else      rdata[CTRL_W-1:0]  = ctrl_q;
    end

endmodule

// File: rtl/pfm_pad_sel.sv
module pfm_pad_sel
    import pfm_pkg::*;
#(
    parameter int       EN_W = 46,
    parameter pad_cfg_t CFG  = '0
) (
    input  logic [EN_W-1:0]      en_vec,
    input  logic [NUM_SLOTS-1:0] fn_do,
    input  logic [NUM_SLOTS-1:0] fn_oe,
    input  logic                 pad_di,
    output logic [NUM_SLOTS-1:0] fn_di,
    output logic                 pad_do,
    output logic                 pad_oe
);

    logic [NUM_SLOTS-1:0] req;
    logic [SEL_W-1:0]     win;
    dir_e                 wdir;

    // Per-slot request: present, enable index in range, enable bit high.
    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_req
            if (s == 0 || CFG[s].dir == DIR_NONE || int'(CFG[s].en_idx) >= EN_W) begin : g_off
                assign req[s] = 1'b0;
            end else begin : g_on
                assign req[s] = en_vec[CFG[s].en_idx];
            end
        end
    endgenerate

    // Ascending scan: a later (higher) slot overrides a lower one.
    always_comb begin
        win = '0;
        for (int s = 1; s < NUM_SLOTS; s++) begin
            if (req[s]) win = SEL_W'(s);
        end
        wdir = CFG[win].dir;
    end

    always_comb begin
        pad_do = (wdir == DIR_NONE) ? 1'b0 : fn_do[win];
        case (wdir)
            DIR_BI:  pad_oe = fn_oe[win];
            DIR_OUT: pad_oe = 1'b1;
            default: pad_oe = 1'b0;
        endcase
    end

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_in
            if (CFG[s].dir == DIR_IN || CFG[s].dir == DIR_BI) begin : g_rx
                assign fn_di[s] = (win == SEL_W'(s)) ? pad_di : CFG[s].idle;
            end else begin : g_idle
                assign fn_di[s] = CFG[s].idle;
            end
        end
    endgenerate

endmodule

// File: rtl/pfm_top.sv
module pfm_top
    import pfm_pkg::*;
#(
    parameter int                        NUM_PADS  = DEF_PADS,
    parameter int                        DATA_W    = 32,
    parameter int                        CTRL_W    = 24,
    parameter int                        SHARE_W   = 22,
    parameter logic [CTRL_W-1:0]         CTRL_MASK = 24'hFF3FFF,
    parameter pad_cfg_t [NUM_PADS-1:0]   PAD_MAP   = default_map()
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic                                cfg_addr,
    input  logic [DATA_W-1:0]                   cfg_wdata,
    output logic [DATA_W-1:0]                   cfg_rdata,
    input  logic [NUM_PADS-1:0][NUM_SLOTS-1:0]  fn_do,
    input  logic [NUM_PADS-1:0][NUM_SLOTS-1:0]  fn_oe,
    output logic [NUM_PADS-1:0][NUM_SLOTS-1:0]  fn_di,
    input  logic [NUM_PADS-1:0]                 pad_di,
    output logic [NUM_PADS-1:0]                 pad_do,
    output logic [NUM_PADS-1:0]                 pad_oe
);

    localparam int EN_W = CTRL_W + SHARE_W;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [SHARE_W-1:0] share_q;
    logic [EN_W-1:0]    en_vec;

    pfm_regs #(
        .DATA_W   (DATA_W),
        .CTRL_W   (CTRL_W),
        .SHARE_W  (SHARE_W),
        .CTRL_MASK(CTRL_MASK)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .ctrl_q (ctrl_q),
        .share_q(share_q)
    );

    assign en_vec = {share_q, ctrl_q};

    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
            pfm_pad_sel #(
                .EN_W(EN_W),
                .CFG (PAD_MAP[p])
            ) u_sel (
                .en_vec(en_vec),
                .fn_do (fn_do[p]),
                .fn_oe (fn_oe[p]),
                .pad_di(pad_di[p]),
                .fn_di (fn_di[p]),
                .pad_do(pad_do[p]),
                .pad_oe(pad_oe[p])
            );
        end
    endgenerate

endmodule

// File: rtl/pfm_chk.sv
module pfm_chk
    import pfm_pkg::*;
#(
    parameter int                      NUM_PADS = DEF_PADS,
    parameter int                      CTRL_W   = 24,
    parameter int                      SHARE_W  = 22,
    parameter pad_cfg_t [NUM_PADS-1:0] PAD_MAP  = default_map()
) (
    input logic                               clk,
    input logic                               rst,
    input logic [CTRL_W-1:0]                  ctrl_q,
    input logic [SHARE_W-1:0]                 share_q,
    input logic [NUM_PADS-1:0][NUM_SLOTS-1:0] fn_do,
    input logic [NUM_PADS-1:0][NUM_SLOTS-1:0] fn_oe,
    input logic [NUM_PADS-1:0][NUM_SLOTS-1:0] fn_di,
    input logic [NUM_PADS-1:0]                pad_di,
    input logic [NUM_PADS-1:0]                pad_do,
    input logic [NUM_PADS-1:0]                pad_oe
);

    localparam int EN_W = CTRL_W + SHARE_W;

    logic [EN_W-1:0] en_all;
    int              own [NUM_PADS];

    assign en_all = {share_q, ctrl_q};

    // Descending scan: first present, enabled slot from the top wins.
    always_comb begin
        for (int p = 0; p < NUM_PADS; p++) begin
            own[p] = 0;
            for (int s = NUM_SLOTS - 1; s >= 1; s--) begin
                if (own[p] == 0 && PAD_MAP[p][s].dir != DIR_NONE
                    && int'(PAD_MAP[p][s].en_idx) < EN_W
                    && en_all[PAD_MAP[p][s].en_idx])
                    own[p] = s;
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == '0 && share_q == '0));

    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_p
            p_route_out_r5: assert property (@(posedge clk) disable iff (rst)
                (PAD_MAP[p][own[p]].dir != DIR_NONE) |-> (pad_do[p] == fn_do[p][own[p]]));
            p_in_never_drives_r5: assert property (@(posedge clk) disable iff (rst)
                (PAD_MAP[p][own[p]].dir == DIR_IN) |-> !pad_oe[p]);
            p_out_always_drives_r5: assert property (@(posedge clk) disable iff (rst)
                (PAD_MAP[p][own[p]].dir == DIR_OUT) |-> pad_oe[p]);
            p_absent_quiet_r7: assert property (@(posedge clk) disable iff (rst)
                (PAD_MAP[p][own[p]].dir == DIR_NONE) |-> (!pad_oe[p] && !pad_do[p]));
            for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_s
                p_unsel_idle_r6: assert property (@(posedge clk) disable iff (rst)
                    (own[p] != s) |-> (fn_di[p][s] == PAD_MAP[p][s].idle));
            end
        end
    endgenerate

endmodule

bind pfm_top pfm_chk #(
    .NUM_PADS(NUM_PADS),
    .CTRL_W  (CTRL_W),
    .SHARE_W (SHARE_W),
    .PAD_MAP (PAD_MAP)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctrl_q (ctrl_q),
    .share_q(share_q),
    .fn_do  (fn_do),
    .fn_oe  (fn_oe),
    .fn_di  (fn_di),
    .pad_di (pad_di),
    .pad_do (pad_do),
    .pad_oe (pad_oe)
);

// File: tb/tb_pfm_top.sv
module tb_pfm_top;
    import pfm_pkg::*;

    localparam int CLK_P   = 10;
    localparam int NP      = 4;
    localparam int NS      = NUM_SLOTS;
    localparam logic [23:0] KEEP = 24'hFF3FFF;

    typedef pad_cfg_t [NP-1:0] tb_map_t;

    function automatic tb_map_t tb_map();
        tb_map_t m;
        m = '0;
        m[0][0] = mk_slot(DIR_BI,  1'b0, 0);
        m[0][1] = mk_slot(DIR_OUT, 1'b0, 0);
        m[0][2] = mk_slot(DIR_IN,  1'b1, 0);
        m[0][3] = mk_slot(DIR_BI,  1'b0, 24);
        m[0][4] = mk_slot(DIR_IN,  1'b0, 13);
        m[1][0] = mk_slot(DIR_IN,  1'b1, 0);
        m[1][1] = mk_slot(DIR_BI,  1'b0, 4);
        m[1][2] = mk_slot(DIR_NONE,1'b0, 5);
        m[1][3] = mk_slot(DIR_OUT, 1'b0, 45);
        m[2][0] = mk_slot(DIR_OUT, 1'b0, 0);
        m[2][1] = mk_slot(DIR_IN,  1'b0, 4);
        m[2][2] = mk_slot(DIR_OUT, 1'b0, 16);
        m[2][3] = mk_slot(DIR_BI,  1'b0, 25);
        m[2][4] = mk_slot(DIR_OUT, 1'b0, 23);
        m[3][0] = mk_slot(DIR_BI,  1'b0, 0);
        return m;
    endfunction

    localparam tb_map_t MAP = tb_map();

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      cfg_we = 1'b0;
    logic                      cfg_addr = 1'b0;
    logic [31:0]               cfg_wdata = '0;
    logic [31:0]               cfg_rdata;
    logic [NP-1:0][NS-1:0]     fn_do = '0;
    logic [NP-1:0][NS-1:0]     fn_oe = '0;
    logic [NP-1:0][NS-1:0]     fn_di;
    logic [NP-1:0]             pad_di = '0;
    logic [NP-1:0]             pad_do;
    logic [NP-1:0]             pad_oe;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic [23:0] m_ctrl = '0;
    logic [21:0] m_share = '0;

    always #(CLK_P/2) clk = ~clk;

    pfm_top #(
        .NUM_PADS(NP),
        .PAD_MAP (MAP)
    ) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fn_do(fn_do), .fn_oe(fn_oe), .fn_di(fn_di),
        .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_owner(int p);
        logic [45:0] en;
        int w;
        en = {m_share, m_ctrl};
        w = 0;
        for (int s = NS - 1; s >= 1; s--)
            if (w == 0 && MAP[p][s].dir != DIR_NONE && en[MAP[p][s].en_idx]) w = s;
        return w;
    endfunction

    task automatic check_pads(string req);
        for (int p = 0; p < NP; p++) begin
            int w;
            dir_e d;
            logic e_do, e_oe;
            logic [NS-1:0] e_di;
            w = exp_owner(p);
            d = MAP[p][w].dir;
            e_do = (d == DIR_NONE) ? 1'b0 : fn_do[p][w];
            e_oe = (d == DIR_OUT) ? 1'b1 : (d == DIR_BI) ? fn_oe[p][w] : 1'b0;
            for (int s = 0; s < NS; s++)
                e_di[s] = (s == w && (MAP[p][s].dir == DIR_IN || MAP[p][s].dir == DIR_BI))
                          ? pad_di[p] : MAP[p][s].idle;
            chk(req, $sformatf("pad%0d pad_do", p), 32'(pad_do[p]), 32'(e_do));
            chk(req, $sformatf("pad%0d pad_oe", p), 32'(pad_oe[p]), 32'(e_oe));
            chk(req, $sformatf("pad%0d fn_di", p), 32'(fn_di[p]), 32'(e_di));
        end
    endtask

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a) m_share = d[21:0];
        else   m_ctrl  = d[23:0] & KEEP;
        #1;
    endtask

    task automatic drive_rand();
        @(negedge clk);
        fn_do  = 20'($urandom());
        fn_oe  = 20'($urandom());
        pad_di = 4'($urandom());
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        cfg_addr = 1'b0; #1;
        chk("R1", "ctrl readback", cfg_rdata, 32'h0);
        cfg_addr = 1'b1; #1;
        chk("R1", "share readback", cfg_rdata, 32'h0);
        drive_rand();
        check_pads("R1 R2");

        // R3 R4: one bit feeds slots 1 and 2 of pad0 -> slot 2 (input-only) wins
        wr(1'b0, 32'h1);
        drive_rand();
        chk("R3", "pad0 oe input-only owner", 32'(pad_oe[0]), 32'h0);
        chk("R6", "pad0 slot2 gets pad", 32'(fn_di[0][2]), 32'(pad_di[0]));
        check_pads("R3 R4");

        // R7: absent slot's enable bit ignored
        wr(1'b0, 32'h20);
        drive_rand();
        chk("R7", "pad1 slot0 input", 32'(fn_di[1][0]), 32'(pad_di[1]));
        chk("R7", "pad1 oe", 32'(pad_oe[1]), 32'h0);
        check_pads("R7");

        // R4: one bit moves pad1 slot1 and pad2 slot1 together
        wr(1'b0, 32'h10);
        drive_rand();
        check_pads("R4 R5");

        // R4 R5: top shared bit -> output-only slot drives
        wr(1'b1, 32'h0020_0000);
        drive_rand();
        chk("R5", "pad1 oe output-only", 32'(pad_oe[1]), 32'h1);
        check_pads("R4 R5");

        // R8: unkept bits read back zero
        wr(1'b0, 32'hFFFF_FFFF);
        cfg_addr = 1'b0; #1;
        chk("R8", "ctrl keep mask", cfg_rdata, 32'h00FF_3FFF);
        wr(1'b1, 32'hFFFF_FFFF);
        cfg_addr = 1'b1; #1;
        chk("R8", "share width", cfg_rdata, 32'h003F_FFFF);
        drive_rand();
        chk("R3", "pad0 slot4 wins", 32'(pad_oe[0]), 32'h0);
        check_pads("R3 R8");

        // R2: all clear again -> slot 0 everywhere
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
        drive_rand();
        check_pads("R2");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            if (i % 3 == 0) wr(1'b0, $urandom());
            if (i % 3 == 1) wr(1'b1, $urandom());
            drive_rand();
            check_pads("R3 R5 R6");
            if (i % 25 == 0) begin
                cfg_addr = 1'b0; #1;
                chk("R8", "ctrl readback", cfg_rdata, 32'(m_ctrl));
                cfg_addr = 1'b1; #1;
                chk("R8", "share readback", cfg_rdata, 32'(m_share));
            end
        end

        // R1: reset mid-run clears everything
        wr(1'b0, 32'h00FF_3FFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ctrl = '0; m_share = '0;
        cfg_addr = 1'b0; #1;
        chk("R1", "ctrl after reset", cfg_rdata, 32'h0);
        drive_rand();
        check_pads("R1");

        finish_run();
    end

endmodule